// File: doc/BRIEF.md
# Asynchronous SRAM Bus Cycle Sequencer

This block sits between a synchronous host and an asynchronous static RAM. The host issues one-cycle requests: an address, a write flag and write data, qualified by `req`. The sequencer turns each request into a strobe sequence for the memory. It drives the address first. It then lowers chip select, runs the write or read strobe, and controls the direction of the shared data bus. On a read it captures the returned byte. Every interval of the sequence is a parameter counted in clock cycles, and each must be at least 1.

The write path uses three named states after the address is driven. `S_WADR` holds the address for the setup time with chip select low and write enable high. `S_WSTB` holds write enable low for the strobe width, and the data bus is driven during its last `T_WDS` cycles. `S_WHLD` releases write enable and keeps the data driven for the hold time.

The read path also uses three states. `S_RDLY` lowers chip select for the strobe delay. `S_RSTB` holds output enable low for `max(T_RE, access)` cycles, where access is the largest of `T_AA`, `T_ACS` and `T_OEA`. The data is captured at the end of strobe cycle number `access`. `S_ROFF` deselects the memory and waits `T_OHZ` cycles so that the memory's outputs can turn off before anything else drives the bus.

From `S_WHLD` or `S_ROFF` the machine returns to `S_IDLE` if the busy period has already reached `T_CYC` cycles. Otherwise it goes to `S_PAD` and waits there until it has. `S_IDLE` accepts a request and moves to `S_WADR` or `S_RDLY`.

`T_WDS` must not exceed `T_WE`.

Top module: `sram_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `ready`=1, `rd_valid`=0, `mem_cs_n`=`mem_we_n`=`mem_oe_n`=1 and `mem_dout_en`=0. A reset in the middle of a cycle abandons that cycle.
- R2: A request is taken only at a clock edge where `req` and `ready` are both 1. `ready` is 0 from the next cycle until the cycle ends. `req` asserted while `ready` is 0 has no effect on the memory.
- R3: `mem_addr` shows the accepted address and stays unchanged while `ready` is 0.
- R4: On a write, `mem_cs_n` is 0 for exactly `T_ASU` cycles before `mem_we_n` falls. `mem_we_n` then stays 0 for exactly `T_WE` cycles.
- R5: `mem_dout_en` is 1 during the last `T_WDS` cycles of the write strobe and for exactly `T_WDH` cycles after it. `mem_dout` carries the accepted write data throughout, so the memory stores that byte.
- R6: On a read, `mem_cs_n` is 0 for exactly `T_RED` cycles before `mem_oe_n` falls. `mem_oe_n` then stays 0 for `max(T_RE, max(T_AA, T_ACS, T_OEA))` cycles.
- R7: `mem_din` is sampled at the end of strobe cycle number `max(T_AA, T_ACS, T_OEA)`. The sampled byte appears on `rd_data` together with a one-cycle `rd_valid` pulse in the same cycle that `ready` returns to 1. `rd_valid` stays 0 after writes.
- R8: After `mem_oe_n` rises, `mem_dout_en` stays 0 for at least `T_OHZ` cycles.
- R9: The busy period (cycles with `ready`=0) lasts `max(T_ASU+T_WE+T_WDH, T_CYC)` cycles for a write and `max(T_RED+strobe+T_OHZ, T_CYC)` cycles for a read.
- R10: `mem_we_n` and `mem_oe_n` are never 0 together. `mem_dout_en` is never 1 while `mem_oe_n` is 0.
- R11: `mem_cs_n` is 0 whenever `mem_we_n` or `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe from the host |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| ready | output | 1 | Idle and able to accept a request |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds read data |
| rd_data | output | DW | Captured read data |
| mem_addr | output | AW | Memory address bus |
| mem_dout | output | DW | Data bus value to drive |
| mem_dout_en | output | 1 | Drive enable for the data bus |
| mem_din | input | DW | Data bus value as received |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
A wrong phase count or a wrong state transition shows up at once as a strobe pulse that is too short or too long, measured from the pin edges. It also shows as a busy period of the wrong length when `ready` returns, within the same memory cycle. A wrongly timed capture returns the memory model's filler byte instead of stored data on the next `rd_valid` pulse. A missing drive or a corrupted latch shows up when the address is next read back. Bus overlaps and strobe overlaps are caught in the cycle in which they happen.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WADR,
        S_WSTB,
        S_WHLD,
        S_RDLY,
        S_RSTB,
        S_ROFF,
        S_PAD
    } seq_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_phase_timer.sv
// Down-counter for the length of the current phase; loaded on every state change.
module seq_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

endmodule

// File: rtl/seq_busy_meter.sv
// Counts cycles of the current bus cycle (1 in its first cycle) and flags the minimum length.
module seq_busy_meter #(
    parameter int CW    = 4,
    parameter int T_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    output logic met
);

    localparam logic [CW-1:0] CYC_C = CW'(T_CYC);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= ONE_C;
        end else if (active && !met) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign met = (cnt >= CYC_C);

endmodule

// File: rtl/seq_datapath.sv
// Request latches, read capture register and read-valid pulse.
module seq_datapath #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          acc_we,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic          capture,
    input  logic [DW-1:0] bus_in,
    input  logic          finish,
    output logic          op_rd,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q,
    output logic          rvalid_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_rd   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            op_rd   <= !acc_we;
            addr_q  <= acc_addr;
            wdata_q <= acc_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= bus_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= finish && op_rd;
        end
    end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_seq_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int T_ASU = 2,
    parameter int T_WE  = 3,
    parameter int T_WDS = 2,
    parameter int T_WDH = 1,
    parameter int T_RED = 1,
    parameter int T_RE  = 4,
    parameter int T_AA  = 3,
    parameter int T_ACS = 2,
    parameter int T_OEA = 2,
    parameter int T_OHZ = 2,
    parameter int T_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dout_en,
    input  logic [DW-1:0] mem_din,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n
);

    localparam int T_ACC  = imax(imax(T_AA, T_ACS), T_OEA);
    localparam int T_RSTB = imax(T_RE, T_ACC);
    localparam int TMAX   = imax(imax(imax(T_ASU, T_WE), imax(T_WDH, T_RED)),
                                 imax(imax(T_RSTB, T_OHZ), T_CYC));
    localparam int CW     = $clog2(TMAX + 1);

    localparam logic [CW-1:0] ASU_L  = CW'(T_ASU - 1);
    localparam logic [CW-1:0] WE_L   = CW'(T_WE - 1);
    localparam logic [CW-1:0] WDH_L  = CW'(T_WDH - 1);
    localparam logic [CW-1:0] RED_L  = CW'(T_RED - 1);
    localparam logic [CW-1:0] RSTB_L = CW'(T_RSTB - 1);
    localparam logic [CW-1:0] OHZ_L  = CW'(T_OHZ - 1);
    localparam logic [CW-1:0] WDS_C  = CW'(T_WDS);
    localparam logic [CW-1:0] CAP_C  = CW'(T_RSTB - T_ACC);

    seq_state_t    state, nxt;
    logic          ph_load, ph_last, accept, finish, cyc_met, op_rd, capture;
    logic [CW-1:0] ph_val, ph_cnt;

    seq_phase_timer #(.CW(CW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .cnt      (ph_cnt),
        .last     (ph_last)
    );

    seq_busy_meter #(.CW(CW), .T_CYC(T_CYC)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .active (state != S_IDLE),
        .met    (cyc_met)
    );

    seq_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .acc_we    (req_we),
        .acc_addr  (req_addr),
        .acc_wdata (req_wdata),
        .capture   (capture),
        .bus_in    (mem_din),
        .finish    (finish),
        .op_rd     (op_rd),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dout),
        .rdata_q   (rd_data),
        .rvalid_q  (rd_valid)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions and phase loads
    always_comb begin
        nxt     = state;
        ph_load = 1'b0;
        ph_val  = '0;
        accept  = 1'b0;
        finish  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (req) begin
                    accept  = 1'b1;
                    ph_load = 1'b1;
                    if (req_we) begin
                        nxt    = S_WADR;
                        ph_val = ASU_L;
                    end else begin
                        nxt    = S_RDLY;
                        ph_val = RED_L;
                    end
                end
            end
            S_WADR: begin
                if (ph_last) begin
                    nxt     = S_WSTB;
                    ph_load = 1'b1;
                    ph_val  = WE_L;
                end
            end
            S_WSTB: begin
                if (ph_last) begin
                    nxt     = S_WHLD;
                    ph_load = 1'b1;
                    ph_val  = WDH_L;
                end
            end
            S_RDLY: begin
                if (ph_last) begin
                    nxt     = S_RSTB;
                    ph_load = 1'b1;
                    ph_val  = RSTB_L;
                end
            end
            S_RSTB: begin
                if (ph_last) begin
                    nxt     = S_ROFF;
                    ph_load = 1'b1;
                    ph_val  = OHZ_L;
                end
            end
            S_WHLD, S_ROFF: begin
                if (ph_last) begin
                    nxt = cyc_met ? S_IDLE : S_PAD;
                end
            end
            S_PAD: begin
                if (cyc_met) begin
                    nxt = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
        finish = (state != S_IDLE) && (nxt == S_IDLE);
    end

    // Outputs decoded from state
    always_comb begin
        ready       = (state == S_IDLE);
        mem_we_n    = (state != S_WSTB);
        mem_oe_n    = (state != S_RSTB);
        mem_cs_n    = !(state == S_WADR || state == S_WSTB || state == S_WHLD ||
                        state == S_RDLY || state == S_RSTB);
        mem_dout_en = ((state == S_WSTB) && (ph_cnt < WDS_C)) || (state == S_WHLD);
        capture     = (state == S_RSTB) && (ph_cnt == CAP_C);
    end

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
    parameter int AW    = 8,
    parameter int T_WE  = 3,
    parameter int T_RE  = 4,
    parameter int T_AA  = 3,
    parameter int T_ACS = 2,
    parameter int T_OEA = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          ready,
    input logic          rd_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_dout_en,
    input logic          mem_cs_n,
    input logic          mem_we_n,
    input logic          mem_oe_n
);

    localparam int T_ACC  = (T_AA > T_ACS) ? ((T_AA > T_OEA) ? T_AA : T_OEA)
                                           : ((T_ACS > T_OEA) ? T_ACS : T_OEA);
    localparam int T_RSTB = (T_RE > T_ACC) ? T_RE : T_ACC;

    logic [15:0] we_run, oe_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run <= '0;
            oe_run <= '0;
        end else begin
            we_run <= mem_we_n ? 16'd0 : we_run + 16'd1;
            oe_run <= mem_oe_n ? 16'd0 : oe_run + 16'd1;
        end
    end

    p_strobe_mutex_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    p_no_drive_in_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dout_en);

    p_cs_covers_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> !mem_cs_n);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(mem_addr));

    p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    p_rvalid_with_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ready);

    p_rvalid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_data_past_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dout_en);

    p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run == 16'(T_WE)));

    p_oe_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_run == 16'(T_RSTB)));

endmodule

bind sram_seq sram_seq_chk #(
    .AW    (AW),
    .T_WE  (T_WE),
    .T_RE  (T_RE),
    .T_AA  (T_AA),
    .T_ACS (T_ACS),
    .T_OEA (T_OEA)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .ready       (ready),
    .rd_valid    (rd_valid),
    .mem_addr    (mem_addr),
    .mem_dout_en (mem_dout_en),
    .mem_cs_n    (mem_cs_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n)
);

// File: tb/test_sram_seq.sv
module test_sram_seq;

    localparam int T_ASU = 2, T_WE = 3, T_WDS = 2, T_WDH = 1, T_RED = 1, T_RE = 4;
    localparam int T_AA = 3, T_ACS = 2, T_OEA = 2, T_OHZ = 2, T_CYC = 8;
    localparam int T_ACC  = 3;
    localparam int T_RSTB = 4;
    localparam int WR_NAT = T_ASU + T_WE + T_WDH;
    localparam int RD_NAT = T_RED + T_RSTB + T_OHZ;
    localparam int WR_LEN = (WR_NAT > T_CYC) ? WR_NAT : T_CYC;
    localparam int RD_LEN = (RD_NAT > T_CYC) ? RD_NAT : T_CYC;

    // {we, addr, wdata, expected read data}
    localparam logic [24:0] VEC [9] = '{
        {1'b1, 8'h03, 8'hA1, 8'h00},
        {1'b1, 8'hFE, 8'h3C, 8'h00},
        {1'b0, 8'h03, 8'h00, 8'hA1},
        {1'b0, 8'hFE, 8'h00, 8'h3C},
        {1'b0, 8'h40, 8'h00, 8'h1A},
        {1'b1, 8'h40, 8'h00, 8'h00},
        {1'b0, 8'h40, 8'h00, 8'h00},
        {1'b1, 8'h00, 8'hFF, 8'h00},
        {1'b0, 8'h00, 8'h00, 8'hFF}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, req_we = 1'b0;
    logic [7:0] req_addr = '0, req_wdata = '0;
    logic       ready, rd_valid, mem_dout_en, mem_cs_n, mem_we_n, mem_oe_n;
    logic [7:0] rd_data, mem_addr, mem_dout, mem_din;

    int n_chk = 0, n_err = 0, wd = 0;
    logic mon_on = 1'b0;

    always #10 clk = ~clk;

    sram_seq i_sram_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    // Memory model: data appears only after T_ACC-1 full strobe cycles.
    logic [7:0] smem [256];
    int oecnt = 0;
    always @(posedge clk) oecnt <= mem_oe_n ? 0 : oecnt + 1;
    assign mem_din = (!mem_cs_n && !mem_oe_n && oecnt >= T_ACC - 1) ? smem[mem_addr] : 8'hEE;
    always @(posedge mem_we_n) if (!mem_cs_n && mem_dout_en) smem[mem_addr] = mem_dout;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Pin-level timing monitor, sampled at the falling edge.
    int pre = 0, we_run = 0, oe_run = 0, ds = 0, dh = 0, since_oe = 100;
    logic pre_done = 1'b0, prev_den = 1'b0;
    always @(negedge clk) begin
        if (!mon_on) begin
            pre = 0; we_run = 0; oe_run = 0; ds = 0; dh = 0; since_oe = 100;
            pre_done = 1'b0; prev_den = 1'b0;
        end else begin
            if (mem_cs_n) begin
                pre = 0; pre_done = 1'b0;
            end else if (!pre_done) begin
                if (!mem_we_n) begin chk("R4 address setup", pre, T_ASU); pre_done = 1'b1; end
                else if (!mem_oe_n) begin chk("R6 strobe delay", pre, T_RED); pre_done = 1'b1; end
                else pre++;
            end
            if (!mem_we_n) we_run++;
            else if (we_run != 0) begin chk("R4 write strobe width", we_run, T_WE); we_run = 0; end
            if (!mem_oe_n) begin oe_run++; since_oe = 0; end
            else begin
                if (oe_run != 0) begin chk("R6 read strobe width", oe_run, T_RSTB); oe_run = 0; end
                if (since_oe < 100) since_oe++;
            end
            if (mem_dout_en && !mem_we_n) ds++;
            if (mem_dout_en && mem_we_n) dh++;
            if (!mem_dout_en && prev_den) begin
                chk("R5 data setup", ds, T_WDS);
                chk("R5 data hold", dh, T_WDH);
                ds = 0; dh = 0;
            end
            if (mem_dout_en && !prev_den) chk("R8 bus turnaround", int'(since_oe >= T_OHZ), 1);
            prev_den = mem_dout_en;
            if (!mem_we_n && !mem_oe_n) chk("R10 strobe overlap", 1, 0);
            if ((!mem_we_n || !mem_oe_n) && mem_cs_n) chk("R11 select cover", 1, 0);
        end
    end

    task automatic do_op(input logic we, input logic [7:0] a, input logic [7:0] d,
                         input logic hold, output int busy, output logic [7:0] rdat,
                         output logic rv, output logic [7:0] addr_seen);
        int n;
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        n = 0;
        addr_seen = 8'h00;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) addr_seen = mem_addr;
            if (hold && !ready) begin
                req = 1'b1; req_we = 1'b1; req_addr = 8'h20; req_wdata = 8'h99;
            end else begin
                req = 1'b0;
            end
        end while (!ready && n < 100);
        busy = n - 1;
        rv = rd_valid;
        rdat = rd_data;
        @(negedge clk);
        chk("R7 rd_valid single pulse", int'(rd_valid), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    always @(negedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d expected below 150000", wd);
            finish_run();
        end
    end

    initial begin
        int busy;
        logic [7:0] rdat, aseen;
        logic rv;
        for (int i = 0; i < 256; i++) smem[i] = 8'(i) ^ 8'h5A;

        // R1: reset state, during and just after reset
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", int'(ready), 1);
        chk("R1 strobes idle in reset", int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
        chk("R1 no drive in reset", int'(mem_dout_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", int'({ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en}), 6'b101110);
        mon_on = 1'b1;

        // Vector table
        for (int v = 0; v < 9; v++) begin
            do_op(VEC[v][24], VEC[v][23:16], VEC[v][15:8], 1'b0, busy, rdat, rv, aseen);
            chk("R3 address on bus", int'(aseen), int'(VEC[v][23:16]));
            if (VEC[v][24]) begin
                chk("R9 write cycle length", busy, WR_LEN);
                chk("R7 no rd_valid after write", int'(rv), 0);
                chk("R5 stored write data", int'(smem[VEC[v][23:16]]), int'(VEC[v][15:8]));
            end else begin
                chk("R9 read cycle length", busy, RD_LEN);
                chk("R7 rd_valid with ready", int'(rv), 1);
                chk("R7 read data", int'(rdat), int'(VEC[v][7:0]));
            end
        end

        // R2: request held high while busy must not start a second cycle
        do_op(1'b1, 8'h10, 8'h77, 1'b1, busy, rdat, rv, aseen);
        chk("R2 busy length with held req", busy, WR_LEN);
        chk("R2 ready stays idle after", int'(ready), 1);
        do_op(1'b0, 8'h20, 8'h00, 1'b0, busy, rdat, rv, aseen);
        chk("R2 ignored write left memory", int'(rdat), int'(8'h20 ^ 8'h5A));
        do_op(1'b0, 8'h10, 8'h00, 1'b0, busy, rdat, rv, aseen);
        chk("R2 accepted write stored", int'(rdat), 8'h77);

        // R1: reset in the middle of a read abandons it
        mon_on = 1'b0;
        req = 1'b1; req_we = 1'b0; req_addr = 8'h03;
        @(negedge clk);
        req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 abort quiets strobes", int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en}), 4'b1110);
        chk("R1 abort restores ready", int'({ready, rd_valid}), 2'b10);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        mon_on = 1'b1;
        do_op(1'b0, 8'hFE, 8'h00, 1'b0, busy, rdat, rv, aseen);
        chk("R1 read after abort", int'(rdat), 8'h3C);

        finish_run();
    end

endmodule